// File: doc/BRIEF.md
# NAND Command Interface: Reset and Status Paths

This block is the device-side command front end of a parallel NAND-style memory, reduced to the reset and status-read paths. Commands are latched from an 8-bit bus by a one-cycle strobe. The block keeps a small status register, an output mode (none, status or page data) and a "device is freshly reset" flag. It drives an active-low ready/busy line and a registered output bus that is enabled by the chip-enable and read-enable inputs. A cycle-counting stub stands in for the array engine that runs program, erase and page-read operations.

A Reset command aborts whatever is running. The ready/busy line then stays low for a recovery time that depends on the interrupted operation. If the aborted work was a program or an erase, a sticky flag marks the target location as invalid. A Read Status command switches the output to the status byte. The status byte follows the live state for as long as the host keeps both enables low. The mode holds until the host issues another command, so an interrupted page read must be commanded again.

Top module: `nand_cmd_status`

## Requirements
- R1: While `rst` is high and in the cycle after it, `rb_n` is 1, `io_oe` is 0 and `loc_invalid` is 0. The fail bit is 0 and the block is in the freshly-reset state.
- R2: Code 0xFF, accepted when the block is not freshly reset, aborts any running operation, clears the fail bit, leaves no output mode and enters the freshly-reset state. From the cycle after the strobe, `rb_n` is low for the recovery time.
- R3: Code 0xFF is ignored while the block is freshly reset, meaning no command other than 0xFF has been accepted since `rst` or since the last accepted 0xFF. In that case `rb_n`, the status and the mode do not change.
- R4: The recovery time is RST_IDLE_CYC cycles when idle, reading or resetting, RST_PROG_CYC cycles when a program is aborted, and RST_ERASE_CYC cycles when an erase is aborted.
- R5: `loc_invalid` rises one cycle after an accepted 0xFF that aborts a program or an erase. It stays high until a later program or erase starts.
- R6: Code 0x70 is accepted even while busy and selects status mode. `io_oe` rises one cycle after both `ce_n` and `re_n` are sampled low, whichever of the two falls later. It drops one cycle after either one is sampled high.
- R7: The status byte has bit 7 = NOT `wr_protect`, bit 6 = 1 when ready and 0 when busy, and bit 0 = fail. All other bits are 0. While the enables stay low, the byte shows on `io_out` one cycle after any change.
- R8: Status mode holds until another command is accepted. A page read interrupted by 0x70 gives no data until code 0x00 is issued again, and the new read restarts at byte 0.
- R9: Code 0x00 holds `rb_n` low for READ_CYC cycles and then enters data mode. Each sampled falling edge of `re_n` with `ce_n` low puts the next byte index (0, 1, 2, ...) on `io_out`.
- R10: Code 0x80 (program) or 0x60 (erase), issued while ready and unprotected, holds `rb_n` low for PROG_CYC or ERASE_CYC cycles and clears the fail bit.
- R11: With `wr_protect` high, 0x80 or 0x60 sets the fail bit and `rb_n` stays high.
- R12: While busy, codes 0x00, 0x80 and 0x60 are ignored. Unknown codes are always ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | One-cycle command latch strobe |
| cmd_byte | input | DATA_W | Command code |
| ce_n | input | 1 | Chip enable, active low |
| re_n | input | 1 | Read enable, active low |
| wr_protect | input | 1 | 1 = program and erase refused |
| io_out | output | DATA_W | Registered output data (status or page byte) |
| io_oe | output | 1 | Output enable for io_out |
| rb_n | output | 1 | Ready (1) / busy (0) |
| loc_invalid | output | 1 | Target of an aborted program/erase is partially modified |

## Verification
Two pairs of events can meet in one cycle. The first is a Reset strobe landing on the very cycle in which a program's countdown expires. At that edge the program still counts as running, so the recovery must use the program length and `loc_invalid` must rise. The bench counts the busy samples after the program strobe and places 0xFF exactly on the expiry edge. The second pair is a status read while a page read is still busy: the status byte must show bit 6 low, and when the read finishes no data may appear. A behavioural model in the bench predicts `rb_n`, `io_oe`, `io_out` and `loc_invalid` every cycle in both cases.

// File: rtl/nand_cs_pkg.sv
package nand_cs_pkg;
  localparam logic [7:0] CMD_RESET  = 8'hFF;
  localparam logic [7:0] CMD_STATUS = 8'h70;
  localparam logic [7:0] CMD_READ   = 8'h00;
  localparam logic [7:0] CMD_PROG   = 8'h80;
  localparam logic [7:0] CMD_ERASE  = 8'h60;

  typedef enum logic [2:0] {
    OP_NONE, OP_READ, OP_PROG, OP_ERASE, OP_RESET
  } op_e;

  typedef enum logic [1:0] {
    MD_NONE, MD_STATUS, MD_DATA
  } mode_e;

  typedef struct packed {
    logic rst_go;   // accepted reset
    logic stat_go;  // status read
    logic arr_go;   // array operation starts
    op_e  arr_op;   // which one
    logic refused;  // program/erase refused by write protect
  } cmd_req_t;
endpackage

// File: rtl/nand_cmd_decode.sv
module nand_cmd_decode
  import nand_cs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              cmd_we,
  input  logic [DATA_W-1:0] cmd_byte,
  input  logic              busy,
  input  logic              in_rst_state,
  input  logic              wr_protect,
  output cmd_req_t          req
);
  logic is_rst, is_stat, is_rd, is_pr, is_er, is_mod;

  always_comb begin
    is_rst  = cmd_we && (cmd_byte == DATA_W'(CMD_RESET));
    is_stat = cmd_we && (cmd_byte == DATA_W'(CMD_STATUS));
    is_rd   = cmd_we && (cmd_byte == DATA_W'(CMD_READ));
    is_pr   = cmd_we && (cmd_byte == DATA_W'(CMD_PROG));
    is_er   = cmd_we && (cmd_byte == DATA_W'(CMD_ERASE));
    is_mod  = is_pr || is_er;

    req.rst_go  = is_rst && !in_rst_state;
    req.stat_go = is_stat;
    req.arr_go  = !busy && (is_rd || (is_mod && !wr_protect));
    req.refused = !busy && is_mod && wr_protect;
    if (is_rd)      req.arr_op = OP_READ;
    else if (is_pr) req.arr_op = OP_PROG;
    else if (is_er) req.arr_op = OP_ERASE;
    else            req.arr_op = OP_NONE;
  end
endmodule

// File: rtl/nand_op_engine.sv
module nand_op_engine
  import nand_cs_pkg::*;
#(
  parameter int READ_CYC      = 6,
  parameter int PROG_CYC      = 20,
  parameter int ERASE_CYC     = 30,
  parameter int RST_IDLE_CYC  = 3,
  parameter int RST_PROG_CYC  = 8,
  parameter int RST_ERASE_CYC = 12
) (
  input  logic     clk,
  input  logic     rst,
  input  cmd_req_t req,
  output logic     busy,
  output logic     abort_mod
);
  localparam int MAX_A   = (READ_CYC > PROG_CYC) ? READ_CYC : PROG_CYC;
  localparam int MAX_B   = (ERASE_CYC > MAX_A) ? ERASE_CYC : MAX_A;
  localparam int MAX_C   = (RST_ERASE_CYC > RST_PROG_CYC) ? RST_ERASE_CYC : RST_PROG_CYC;
  localparam int MAX_D   = (RST_IDLE_CYC > MAX_C) ? RST_IDLE_CYC : MAX_C;
  localparam int MAX_ALL = (MAX_B > MAX_D) ? MAX_B : MAX_D;
  localparam int CNT_W   = $clog2(MAX_ALL + 1);

  logic [CNT_W-1:0] cnt_q, rst_len, op_len;
  op_e              op_q;

  // recovery length chosen by what is running at the strobe edge
  always_comb begin
    if (busy && op_q == OP_PROG)       rst_len = CNT_W'(RST_PROG_CYC);
    else if (busy && op_q == OP_ERASE) rst_len = CNT_W'(RST_ERASE_CYC);
    else                               rst_len = CNT_W'(RST_IDLE_CYC);
    case (req.arr_op)
      OP_PROG:  op_len = CNT_W'(PROG_CYC);
      OP_ERASE: op_len = CNT_W'(ERASE_CYC);
      default:  op_len = CNT_W'(READ_CYC);
    endcase
  end

  assign abort_mod = req.rst_go && busy && (op_q == OP_PROG || op_q == OP_ERASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      op_q  <= OP_NONE;
    end else if (req.rst_go) begin
      busy  <= 1'b1;
      cnt_q <= rst_len;
      op_q  <= OP_RESET;
    end else if (req.arr_go) begin
      busy  <= 1'b1;
      cnt_q <= op_len;
      op_q  <= req.arr_op;
    end else if (busy) begin
      if (cnt_q == CNT_W'(1)) begin
        busy  <= 1'b0;
        cnt_q <= '0;
        op_q  <= OP_NONE;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/nand_io_out.sv
module nand_io_out
  import nand_cs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              re_n,
  input  mode_e             mode,
  input  logic              busy,
  input  logic              ptr_clear,
  input  logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] io_out,
  output logic              io_oe
);
  logic [DATA_W-1:0] ptr_q;
  logic              re_q;
  logic              data_live;

  assign data_live = (mode == MD_DATA) && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      re_q   <= 1'b1;
      io_out <= '0;
      io_oe  <= 1'b0;
    end else begin
      re_q   <= re_n;
      io_oe  <= !ce_n && !re_n && ((mode == MD_STATUS) || data_live);
      io_out <= (mode == MD_STATUS) ? status : ptr_q;
      if (ptr_clear)
        ptr_q <= '0;
      else if (data_live && !ce_n && re_q && !re_n)
        ptr_q <= ptr_q + DATA_W'(1);
    end
  end
endmodule

// File: rtl/nand_cmd_status.sv
module nand_cmd_status
  import nand_cs_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int READ_CYC      = 6,
  parameter int PROG_CYC      = 20,
  parameter int ERASE_CYC     = 30,
  parameter int RST_IDLE_CYC  = 3,
  parameter int RST_PROG_CYC  = 8,
  parameter int RST_ERASE_CYC = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic [DATA_W-1:0] cmd_byte,
  input  logic              ce_n,
  input  logic              re_n,
  input  logic              wr_protect,
  output logic [DATA_W-1:0] io_out,
  output logic              io_oe,
  output logic              rb_n,
  output logic              loc_invalid
);
  cmd_req_t          req;
  logic              busy, abort_mod;
  mode_e             mode_q;
  logic              fail_q, dev_rst_q;
  logic              status_mode;
  logic [DATA_W-1:0] status_byte;

  nand_cmd_decode #(.DATA_W(DATA_W)) u_dec (
    .cmd_we(cmd_we), .cmd_byte(cmd_byte), .busy(busy),
    .in_rst_state(dev_rst_q), .wr_protect(wr_protect), .req(req)
  );

  nand_op_engine #(
    .READ_CYC(READ_CYC), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
    .RST_IDLE_CYC(RST_IDLE_CYC), .RST_PROG_CYC(RST_PROG_CYC),
    .RST_ERASE_CYC(RST_ERASE_CYC)
  ) u_eng (
    .clk(clk), .rst(rst), .req(req), .busy(busy), .abort_mod(abort_mod)
  );

  always_comb begin
    status_byte           = '0;
    status_byte[DATA_W-1] = !wr_protect;
    status_byte[DATA_W-2] = !busy;
    status_byte[0]        = fail_q;
  end

  assign status_mode = (mode_q == MD_STATUS);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= MD_NONE;
      fail_q      <= 1'b0;
      dev_rst_q   <= 1'b1;
      loc_invalid <= 1'b0;
    end else if (req.rst_go) begin
      mode_q    <= MD_NONE;
      fail_q    <= 1'b0;
      dev_rst_q <= 1'b1;
      if (abort_mod) loc_invalid <= 1'b1;
    end else if (req.stat_go) begin
      mode_q    <= MD_STATUS;
      dev_rst_q <= 1'b0;
    end else if (req.arr_go) begin
      dev_rst_q <= 1'b0;
      if (req.arr_op == OP_READ) begin
        mode_q <= MD_DATA;
      end else begin
        mode_q      <= MD_NONE;
        fail_q      <= 1'b0;
        loc_invalid <= 1'b0;
      end
    end else if (req.refused) begin
      mode_q    <= MD_NONE;
      dev_rst_q <= 1'b0;
      fail_q    <= 1'b1;
    end
  end

  nand_io_out #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .ce_n(ce_n), .re_n(re_n), .mode(mode_q),
    .busy(busy), .ptr_clear(req.arr_go && req.arr_op == OP_READ),
    .status(status_byte), .io_out(io_out), .io_oe(io_oe)
  );

  assign rb_n = !busy;
endmodule

// File: rtl/nand_cmd_status_chk.sv
module nand_cmd_status_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_we,
  input logic [DW-1:0] cmd_byte,
  input logic          wr_protect,
  input logic          rb_n,
  input logic          io_oe,
  input logic [DW-1:0] io_out,
  input logic          loc_invalid,
  input logic          in_rst_state,
  input logic          status_mode
);
  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (rb_n && !io_oe && !loc_invalid));

  // R2
  a_r2_reset_goes_busy: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && cmd_byte == DW'(8'hFF) && !in_rst_state) |=> !rb_n);

  // R3
  a_r3_repeat_reset_ignored: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && cmd_byte == DW'(8'hFF) && in_rst_state && rb_n) |=> rb_n);

  // R5
  a_r5_invalid_after_abort: assert property (@(posedge clk) disable iff (rst)
    $rose(loc_invalid) |-> $past(cmd_we && cmd_byte == DW'(8'hFF) && !rb_n));

  // R7
  a_r7_status_wp_bit: assert property (@(posedge clk) disable iff (rst)
    (io_oe && $past(status_mode)) |-> (io_out[DW-1] == !$past(wr_protect)));

  // R11
  a_r11_protect_stays_ready: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && wr_protect && rb_n &&
     (cmd_byte == DW'(8'h80) || cmd_byte == DW'(8'h60))) |=> rb_n);
endmodule

bind nand_cmd_status nand_cmd_status_chk #(.DW(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
  .wr_protect(wr_protect), .rb_n(rb_n), .io_oe(io_oe), .io_out(io_out),
  .loc_invalid(loc_invalid), .in_rst_state(dev_rst_q), .status_mode(status_mode)
);

// File: tb/test_nand_cmd_status.sv
`timescale 1ns/1ps
module test_nand_cmd_status;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_we = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic       ce_n = 1'b1, re_n = 1'b1, wr_protect = 1'b0;
  logic [7:0] io_out;
  logic       io_oe, rb_n, loc_invalid;

  always #4 clk = ~clk;

  nand_cmd_status i_nand_cmd_status (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
    .ce_n(ce_n), .re_n(re_n), .wr_protect(wr_protect),
    .io_out(io_out), .io_oe(io_oe), .rb_n(rb_n), .loc_invalid(loc_invalid)
  );

  int compared = 0, mismatched = 0, busy_seen = 0;
  bit done = 0;

  // behavioural model state
  bit       m_busy, m_fail, m_devrst, m_inval, m_req, m_oe;
  int       m_cnt, m_op, m_mode;   // op: 0 none 1 read 2 prog 3 erase 4 reset; mode: 0 none 1 status 2 data
  bit [7:0] m_ptr, m_out;

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_step();
    bit [7:0] st;
    bit is_rst, is_stat, is_rd, is_mod, rst_go, arr_go, refused, abort;
    int len;
    if (rst) begin
      m_busy = 0; m_cnt = 0; m_op = 0; m_mode = 0; m_fail = 0; m_devrst = 1;
      m_inval = 0; m_ptr = 0; m_req = 1; m_oe = 0; m_out = 0;
      return;
    end
    st = {!wr_protect, !m_busy, 5'b0, m_fail};
    is_rst  = cmd_we && cmd_byte == 8'hFF;
    is_stat = cmd_we && cmd_byte == 8'h70;
    is_rd   = cmd_we && cmd_byte == 8'h00;
    is_mod  = cmd_we && (cmd_byte == 8'h80 || cmd_byte == 8'h60);
    rst_go  = is_rst && !m_devrst;
    arr_go  = !m_busy && (is_rd || (is_mod && !wr_protect));
    refused = !m_busy && is_mod && wr_protect;
    abort   = rst_go && m_busy && (m_op == 2 || m_op == 3);
    // output stage
    m_oe  = !ce_n && !re_n && (m_mode == 1 || (m_mode == 2 && !m_busy));
    m_out = (m_mode == 1) ? st : m_ptr;
    if (arr_go && is_rd) m_ptr = 0;
    else if (m_mode == 2 && !m_busy && !ce_n && m_req && !re_n) m_ptr = m_ptr + 1;
    m_req = re_n;
    // engine
    if (rst_go) begin
      len = (m_busy && m_op == 2) ? 8 : (m_busy && m_op == 3) ? 12 : 3;
      m_busy = 1; m_cnt = len; m_op = 4;
    end else if (arr_go) begin
      m_busy = 1;
      m_op   = is_rd ? 1 : (cmd_byte == 8'h80 ? 2 : 3);
      m_cnt  = (m_op == 1) ? 6 : (m_op == 2) ? 20 : 30;
    end else if (m_busy) begin
      if (m_cnt == 1) begin m_busy = 0; m_op = 0; m_cnt = 0; end
      else m_cnt--;
    end
    // control state
    if (rst_go) begin
      m_mode = 0; m_fail = 0; m_devrst = 1;
      if (abort) m_inval = 1;
    end else if (is_stat) begin
      m_mode = 1; m_devrst = 0;
    end else if (arr_go) begin
      m_devrst = 0;
      if (is_rd) m_mode = 2;
      else begin m_mode = 0; m_fail = 0; m_inval = 0; end
    end else if (refused) begin
      m_mode = 0; m_devrst = 0; m_fail = 1;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R4 rb_n", rb_n, !m_busy);
    chk("R6 io_oe", io_oe, m_oe);
    chk("R7 io_out", io_out, m_out);
    chk("R5 loc_invalid", loc_invalid, m_inval);
    if (!rb_n) busy_seen++;
  endtask

  task automatic cmd(input bit [7:0] b);
    cmd_we = 1; cmd_byte = b;
    tick();
    cmd_we = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wait_ready();
    while (!rb_n) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 0;
    tick();
    chk("R1 rb_n", rb_n, 1);
    chk("R1 io_oe", io_oe, 0);
    chk("R1 loc_invalid", loc_invalid, 0);

    // R3: reset while freshly reset
    busy_seen = 0; cmd(8'hFF); idle(3);
    chk("R3 busy", busy_seen, 0);

    // R6 / R7: status mode, live update
    cmd(8'h70); ce_n = 0; re_n = 0; idle(2);
    chk("R6 oe", io_oe, 1);
    chk("R7 status", io_out, 8'hC0);
    wr_protect = 1; tick();
    chk("R7 live wp", io_out, 8'h40);
    wr_protect = 0; ce_n = 1; re_n = 1; tick();
    chk("R6 oe off", io_oe, 0);

    // R2: accepted reset while idle
    busy_seen = 0; cmd(8'hFF); wait_ready();
    chk("R2 busy", busy_seen, 3);

    // R9: page read
    busy_seen = 0; cmd(8'h00); wait_ready();
    chk("R9 busy", busy_seen, 6);
    ce_n = 0;
    for (int i = 0; i < 3; i++) begin
      re_n = 0; tick();
      chk("R9 oe", io_oe, 1);
      chk("R9 byte", io_out, i);
      re_n = 1; tick();
    end
    ce_n = 1;

    // R8: status during read; data needs a new read
    cmd(8'h00); idle(2);
    cmd(8'h70);
    ce_n = 0; re_n = 0; tick();
    chk("R8 busy status", io_out, 8'h80);
    wait_ready(); tick();
    chk("R8 still status", io_out, 8'hC0);
    ce_n = 1; re_n = 1;
    cmd(8'h00); wait_ready();
    ce_n = 0; re_n = 0; tick();
    chk("R8 restart", io_out, 0);
    ce_n = 1; re_n = 1; tick();

    // R10 / R12: program with ignored commands
    busy_seen = 0; cmd(8'h80); idle(2);
    cmd(8'h80); cmd(8'h00); cmd(8'h33); cmd(8'h60);
    wait_ready();
    chk("R12 busy", busy_seen, 20);
    busy_seen = 0; cmd(8'h60); wait_ready();
    chk("R10 erase", busy_seen, 30);

    // R4 / R5: abort program and erase
    busy_seen = 0; cmd(8'h80); idle(4); cmd(8'hFF);
    chk("R5 set", loc_invalid, 1);
    wait_ready();
    chk("R4 prog abort", busy_seen, 13);
    busy_seen = 0; cmd(8'h60);
    chk("R5 cleared", loc_invalid, 0);
    idle(2); cmd(8'hFF); wait_ready();
    chk("R4 erase abort", busy_seen, 15);

    // same cycle: reset on the program's last busy cycle
    busy_seen = 0; cmd(8'h80);
    while (busy_seen < 20) tick();
    cmd(8'hFF);
    chk("R5 edge abort", loc_invalid, 1);
    wait_ready();
    chk("R4 edge abort", busy_seen, 28);

    // R11: protected program/erase
    wr_protect = 1;
    busy_seen = 0; cmd(8'h80); tick();
    chk("R11 no busy", busy_seen, 0);
    ce_n = 0; re_n = 0;
    cmd(8'h70); tick();
    chk("R11 fail bit", io_out, 8'h41);
    cmd(8'h60); tick();
    chk("R11 erase no busy", busy_seen, 0);
    cmd(8'hFF); wait_ready();
    wr_protect = 0;
    cmd(8'h70); tick();
    chk("R2 fail cleared", io_out, 8'hC0);
    ce_n = 1; re_n = 1;

    // reset while reading: idle recovery
    busy_seen = 0; cmd(8'h00); tick(); cmd(8'hFF); wait_ready();
    chk("R4 read abort", busy_seen, 5);
    idle(3);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule